// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps the time of day and the calendar date as packed BCD fields held in registers. A base tick input is divided by a small prescaler into hundredths of a second, and each hundredth rolls over into seconds, minutes and hours. Each day advances a day-of-week count, a day-of-month count, the month and the year. A century flag can flip when the year wraps from 99 to 00.

Software reaches every field through a flat register port. The port has a write strobe, a 5-bit address and a byte of write data, and read data comes back combinationally for the address presented. A stop control freezes all counting. A sticky oscillator-fail flag is raised whenever counting is stopped or the clock-activity input reports no oscillation. Software can clear the flag, but only while oscillation is present.

Top module: `rtcal_core`

## Requirements
- R1: After reset every time and date field reads 0, stop, century-enable and century read 0, and the oscillator-fail flag reads 1, so address 01h and address 09h both read 80h.
- R2: The hundredths field (address 1Fh) advances by one BCD step once every TICKS_PER_CS accepted ticks and runs 00..99. Its wrap from 99 to 00 carries into seconds.
- R3: Seconds (00h, bits 6:0) and minutes (01h, bits 6:0) count 00..59 in BCD, and hours (02h, bits 5:0) count 00..23. Each wrap carries into the next field.
- R4: Day of week (03h, bits 2:0) advances on every hour wrap in the cycle 1,2,...,7,1.
- R5: The day of month (04h, bits 5:0) returns to 01 after the month's last day, which is 30 for months 04, 06, 09 and 11, 28 for month 02 (29 when the BCD year is a multiple of 4), and 31 otherwise. Month (05h, bits 4:0) wraps 12 to 01 and carries into year (06h), which wraps 99 to 00.
- R6: Address 02h bit 6 is the century enable and bit 7 the century flag. The flag inverts on the year wrap only when the enable is 1, and otherwise keeps its value.
- R7: While the stop bit (00h bit 7) is 1, neither the prescaler nor any field advances.
- R8: While the stop bit is 1 or osc_ok_i is 0, the oscillator-fail flag is 1 from the next clock edge on. The flag reads at 01h bit 7 and at 09h bit 7.
- R9: A write with data bit 7 equal to 0 at 01h or 09h clears the fail flag, but only when osc_ok_i is 1 and stop is 0. A write of 1 never sets it.
- R10: A register write takes priority over a tick in the same cycle. That tick is discarded and does not move the prescaler or any field.
- R11: Writing the hundredths field resets the prescaler phase, so the next hundredths step needs a full TICKS_PER_CS ticks.
- R12: Unused bits read 0 whatever was written: 03h bits 7:3, 04h bits 7:6, 05h bits 7:5 and 09h bits 6:0. Unmapped addresses read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle base tick, TICKS_PER_CS per hundredth of a second |
| osc_ok_i | input | 1 | 1 when clock activity is present |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address for reads and writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |

## Verification
A register write and a tick can arrive in the same cycle. So can a clear of the fail flag and a condition that sets it. The bench makes the first happen by writing the year while a tick is present and the prescaler sits one tick short of a carry. It then reads the hundredths field in the next cycle and again after one more tick, which shows that the tick was discarded. The second is made by clearing the flag while stop is set, and again while osc_ok_i is low. A behavioural model compares every read against the expected value on every clock.

// File: rtl/rtcal_pkg.sv
package rtcal_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    RA_SEC  = 5'h00,
    RA_MIN  = 5'h01,
    RA_HOUR = 5'h02,
    RA_WDAY = 5'h03,
    RA_DAY  = 5'h04,
    RA_MON  = 5'h05,
    RA_YEAR = 5'h06,
    RA_FLAG = 5'h09,
    RA_CSEC = 5'h1F
  } reg_addr_e;
endpackage

// File: rtl/rtcal_rst_sync.sv
module rtcal_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/rtcal_prescale.sv
module rtcal_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic clr_i,
  output logic carry_o
);
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             carry;

  always_comb begin
    cnt_d = cnt_q;
    carry = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
    end else if (tick_i && en_i) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        carry = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign carry_o = carry;

  // R11: a phase clear leaves the prescaler at zero
  assert_phase_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)) else $error("prescaler phase not cleared");

  // R7: no accepted tick, no phase movement
  assert_phase_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !(tick_i && en_i)) |=> $stable(cnt_q)) else $error("prescaler moved");
endmodule

// File: rtl/rtcal_bcd_ctr.sv
module rtcal_bcd_ctr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         inc_i,
  input  logic [W-1:0] min_i,
  input  logic [W-1:0] max_i,
  output logic [W-1:0] val_o,
  output logic         wrap_o
);
  logic [W-1:0] val_q, val_d, val_inc;
  logic         at_max;

  assign at_max = (val_q == max_i);

  generate
    if (W > 4) begin : g_two_digit
      always_comb begin
        if (val_q[3:0] == 4'h9) val_inc = {val_q[W-1:4] + (W-4)'(1), 4'h0};
        else                    val_inc = val_q + W'(1);
      end
    end else begin : g_one_digit
      assign val_inc = val_q + W'(1);
    end
  endgenerate

  always_comb begin
    val_d = val_q;
    if (ld_i)                 val_d = ld_val_i;
    else if (inc_i && at_max) val_d = min_i;
    else if (inc_i)           val_d = val_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= '0;
    else         val_q <= val_d;
  end

  assign val_o  = val_q;
  assign wrap_o = inc_i & at_max & ~ld_i;

  // R3: a step from the top value lands on the bottom value
  assert_ctr_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i && at_max) |=> (val_q == $past(min_i))) else $error("field did not wrap");

  // R7: without a step or a load the field holds
  assert_ctr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !ld_i) |=> $stable(val_q)) else $error("field moved without cause");
endmodule

// File: rtl/rtcal_month_len.sv
module rtcal_month_len (
  input  logic [4:0] mon_i,
  input  logic       leap_i,
  output logic [5:0] last_o
);
  always_comb begin
    case (mon_i)
      5'h02:                      last_o = leap_i ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_o = 6'h30;
      default:                    last_o = 6'h31;
    endcase
  end
endmodule

// File: rtl/rtcal_core.sv
module rtcal_core
  import rtcal_pkg::*;
#(
  parameter int unsigned TICKS_PER_CS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              osc_ok_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic rst_n;

  logic [7:0] csec, year;
  logic [6:0] sec, minute;
  logic [5:0] hour, day, day_last;
  logic [4:0] mon;
  logic [2:0] wday;

  logic cs_step, c_cs, c_sec, c_min, c_hr, c_day, c_mon, c_yr, wd_wrap;
  logic adv_en, leap_yr;
  logic wr_sec, wr_min, wr_hour, wr_wday, wr_day, wr_mon, wr_year, wr_flag, wr_csec;

  logic stop_q, stop_d, ceb_q, ceb_d, cb_q, cb_d, of_q, of_d;
  logic of_set, of_clr;

  rtcal_rst_sync u_rst (.clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n));

  // write decode
  assign wr_sec  = wr_en_i && (addr_i == RA_SEC);
  assign wr_min  = wr_en_i && (addr_i == RA_MIN);
  assign wr_hour = wr_en_i && (addr_i == RA_HOUR);
  assign wr_wday = wr_en_i && (addr_i == RA_WDAY);
  assign wr_day  = wr_en_i && (addr_i == RA_DAY);
  assign wr_mon  = wr_en_i && (addr_i == RA_MON);
  assign wr_year = wr_en_i && (addr_i == RA_YEAR);
  assign wr_flag = wr_en_i && (addr_i == RA_FLAG);
  assign wr_csec = wr_en_i && (addr_i == RA_CSEC);

  // any write cycle drops the tick; stop freezes the chain
  assign adv_en = ~stop_q & ~wr_en_i;

  rtcal_prescale #(.DIV(TICKS_PER_CS)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_n), .tick_i(tick_i), .en_i(adv_en),
    .clr_i(wr_csec), .carry_o(cs_step)
  );

  rtcal_bcd_ctr #(.W(8)) u_csec (
    .clk_i(clk_i), .rst_ni(rst_n), .ld_i(wr_csec), .ld_val_i(wdata_i),
    .inc_i(cs_step), .min_i(8'h00), .max_i(8'h99), .val_o(csec), .wrap_o(c_cs)
  );

  rtcal_bcd_ctr #(.W(7)) u_sec (
    .clk_i(clk_i), .rst_ni(rst_n), .ld_i(wr_sec), .ld_val_i(wdata_i[6:0]),
    .inc_i(c_cs), .min_i(7'h00), .max_i(7'h59), .val_o(sec), .wrap_o(c_sec)
  );

  rtcal_bcd_ctr #(.W(7)) u_min (
    .clk_i(clk_i), .rst_ni(rst_n), .ld_i(wr_min), .ld_val_i(wdata_i[6:0]),
    .inc_i(c_sec), .min_i(7'h00), .max_i(7'h59), .val_o(minute), .wrap_o(c_min)
  );

  rtcal_bcd_ctr #(.W(6)) u_hour (
    .clk_i(clk_i), .rst_ni(rst_n), .ld_i(wr_hour), .ld_val_i(wdata_i[5:0]),
    .inc_i(c_min), .min_i(6'h00), .max_i(6'h23), .val_o(hour), .wrap_o(c_hr)
  );

  rtcal_bcd_ctr #(.W(3)) u_wday (
    .clk_i(clk_i), .rst_ni(rst_n), .ld_i(wr_wday), .ld_val_i(wdata_i[2:0]),
    .inc_i(c_hr), .min_i(3'd1), .max_i(3'd7), .val_o(wday), .wrap_o(wd_wrap)
  );

  // multiple of 4 in BCD: even tens need units 0/4/8, odd tens need units 2/6
  assign leap_yr = year[4] ? (year[1:0] == 2'b10) : (year[1:0] == 2'b00);

  rtcal_month_len u_mlen (.mon_i(mon), .leap_i(leap_yr), .last_o(day_last));

  rtcal_bcd_ctr #(.W(6)) u_day (
    .clk_i(clk_i), .rst_ni(rst_n), .ld_i(wr_day), .ld_val_i(wdata_i[5:0]),
    .inc_i(c_hr), .min_i(6'h01), .max_i(day_last), .val_o(day), .wrap_o(c_day)
  );

  rtcal_bcd_ctr #(.W(5)) u_mon (
    .clk_i(clk_i), .rst_ni(rst_n), .ld_i(wr_mon), .ld_val_i(wdata_i[4:0]),
    .inc_i(c_day), .min_i(5'h01), .max_i(5'h12), .val_o(mon), .wrap_o(c_mon)
  );

  rtcal_bcd_ctr #(.W(8)) u_year (
    .clk_i(clk_i), .rst_ni(rst_n), .ld_i(wr_year), .ld_val_i(wdata_i),
    .inc_i(c_mon), .min_i(8'h00), .max_i(8'h99), .val_o(year), .wrap_o(c_yr)
  );

  // control and flag bits: next state
  assign of_set = ~osc_ok_i | stop_q;
  assign of_clr = (wr_min | wr_flag) & ~wdata_i[7] & ~of_set;

  always_comb begin
    stop_d = wr_sec  ? wdata_i[7] : stop_q;
    ceb_d  = wr_hour ? wdata_i[6] : ceb_q;
    cb_d   = cb_q;
    if (wr_hour)           cb_d = wdata_i[7];
    else if (c_yr && ceb_q) cb_d = ~cb_q;
    of_d   = of_q;
    if (of_set)      of_d = 1'b1;
    else if (of_clr) of_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      ceb_q  <= 1'b0;
      cb_q   <= 1'b0;
      of_q   <= 1'b1;
    end else begin
      stop_q <= stop_d;
      ceb_q  <= ceb_d;
      cb_q   <= cb_d;
      of_q   <= of_d;
    end
  end

  // read mux
  always_comb begin
    case (addr_i)
      RA_SEC:  rdata_o = {stop_q, sec};
      RA_MIN:  rdata_o = {of_q, minute};
      RA_HOUR: rdata_o = {cb_q, ceb_q, hour};
      RA_WDAY: rdata_o = {5'b0, wday};
      RA_DAY:  rdata_o = {2'b0, day};
      RA_MON:  rdata_o = {3'b0, mon};
      RA_YEAR: rdata_o = year;
      RA_FLAG: rdata_o = {of_q, 7'b0};
      RA_CSEC: rdata_o = csec;
      default: rdata_o = 8'h00;
    endcase
  end

  // R4: day of week wraps to 1
  assert_wday_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    wd_wrap |=> (wday == 3'd1)) else $error("day of week did not wrap to 1");

  // R6: century flag holds while disabled
  assert_cb_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!ceb_q && !wr_hour) |=> $stable(cb_q)) else $error("century flag moved while disabled");

  // R7: stopped chain keeps hundredths and seconds
  assert_stop_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (stop_q && !wr_en_i) |=> ($stable(csec) && $stable(sec))) else $error("counting while stopped");

  // R8: missing oscillation raises the flag
  assert_of_set_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!osc_ok_i || stop_q) |=> of_q) else $error("fail flag not raised");

  // R9: only a qualified clear removes the flag
  assert_of_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (of_q && !(wr_min || wr_flag)) |=> of_q) else $error("fail flag dropped without clear");

  // R9: a write of 1 cannot raise the flag
  assert_of_no_set_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!of_q && osc_ok_i && !stop_q) |=> !of_q) else $error("fail flag raised by write");

  // R10: a write cycle swallows the tick
  assert_wr_priority_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && !wr_csec) |=> $stable(csec)) else $error("tick accepted during write");
endmodule

// File: tb/rtcal_core_bench.sv
`timescale 1ns/1ps
module rtcal_core_bench;
  localparam int P = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       osc_ok_i = 1'b1;
  logic       wr_en_i = 1'b0;
  logic [4:0] addr_i = 5'h00;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;

  int n_chk = 0;
  int n_fail = 0;
  int rot = 0;

  // reference model state (plain integers)
  int m_cs, m_s, m_mi, m_h, m_wd, m_d, m_mo, m_y, m_ph;
  bit m_stop, m_ceb, m_cb, m_of;

  always #2 clk_i = ~clk_i;

  rtcal_core #(.TICKS_PER_CS(P)) u_rtcal_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .osc_ok_i(osc_ok_i),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int fb(logic [7:0] d);
    return int'(d[7:4]) * 10 + int'(d[3:0]);
  endfunction

  function automatic int lastday(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] mread(logic [4:0] a);
    case (a)
      5'h00: return {m_stop, 7'(bcd(m_s))};
      5'h01: return {m_of, 7'(bcd(m_mi))};
      5'h02: return {m_cb, m_ceb, 6'(bcd(m_h))};
      5'h03: return 8'(m_wd);
      5'h04: return bcd(m_d);
      5'h05: return bcd(m_mo);
      5'h06: return bcd(m_y);
      5'h09: return {m_of, 7'b0};
      5'h1F: return bcd(m_cs);
      default: return 8'h00;
    endcase
  endfunction

  function automatic string deftag(logic [4:0] a);
    case (a)
      5'h00, 5'h01: return "R3";
      5'h02: return "R6";
      5'h03: return "R4";
      5'h04, 5'h05, 5'h06: return "R5";
      5'h09: return "R8";
      5'h1F: return "R2";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, addr_i, act, exp);
    end
  endtask

  task automatic day_adv();
    m_wd = (m_wd == 7) ? 1 : m_wd + 1;
    if (m_d == lastday(m_mo, m_y)) begin
      m_d = 1;
      if (m_mo == 12) begin
        m_mo = 1;
        m_y = (m_y + 1) % 100;
        if (m_y == 0 && m_ceb) m_cb = !m_cb;
      end else m_mo++;
    end else m_d++;
  endtask

  task automatic cs_adv();
    m_cs = (m_cs + 1) % 100;
    if (m_cs == 0) begin
      m_s = (m_s + 1) % 60;
      if (m_s == 0) begin
        m_mi = (m_mi + 1) % 60;
        if (m_mi == 0) begin
          m_h = (m_h + 1) % 24;
          if (m_h == 0) day_adv();
        end
      end
    end
  endtask

  task automatic model_edge(bit wr, logic [4:0] a, logic [7:0] d, bit tk, bit osc);
    bit set_f;
    bit clr_f;
    set_f = !osc || m_stop;
    clr_f = wr && (a == 5'h01 || a == 5'h09) && !d[7] && !set_f;
    if (wr) begin
      case (a)
        5'h00: begin m_stop = d[7]; m_s = fb(d & 8'h7F); end
        5'h01: m_mi = fb(d & 8'h7F);
        5'h02: begin m_cb = d[7]; m_ceb = d[6]; m_h = fb(d & 8'h3F); end
        5'h03: m_wd = int'(d[2:0]);
        5'h04: m_d = fb(d & 8'h3F);
        5'h05: m_mo = fb(d & 8'h1F);
        5'h06: m_y = fb(d);
        5'h1F: begin m_cs = fb(d); m_ph = 0; end
        default: ;
      endcase
    end else if (tk && !m_stop) begin
      m_ph++;
      if (m_ph == P) begin
        m_ph = 0;
        cs_adv();
      end
    end
    if (set_f) m_of = 1'b1;
    else if (clr_f) m_of = 1'b0;
  endtask

  // one clock: drive, compare model read, then advance model at the edge
  task automatic step(bit wr, logic [4:0] a, logic [7:0] d, bit tk, bit osc,
                      string tag, bit use_exp, logic [7:0] exp);
    @(negedge clk_i);
    wr_en_i = wr; addr_i = a; wdata_i = d; tick_i = tk; osc_ok_i = osc;
    #1;
    chk((tag == "") ? deftag(a) : tag, rdata_o, mread(a));
    if (use_exp) chk(tag, rdata_o, exp);
    @(posedge clk_i);
    model_edge(wr, a, d, tk, osc);
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    step(1'b1, a, d, 1'b0, 1'b1, "", 1'b0, 8'h00);
  endtask

  task automatic tk(int n);
    logic [4:0] seq [10] = '{5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h05, 5'h06, 5'h09, 5'h1F, 5'h0A};
    for (int i = 0; i < n; i++) begin
      step(1'b0, seq[rot % 10], 8'h00, 1'b1, 1'b1, "", 1'b0, 8'h00);
      rot++;
    end
  endtask

  task automatic expect_rd(logic [4:0] a, logic [7:0] exp, string tag);
    step(1'b0, a, 8'h00, 1'b0, 1'b1, tag, 1'b1, exp);
  endtask

  task automatic set_eod();
    wr(5'h02, 8'h23); wr(5'h01, 8'h59); wr(5'h00, 8'h59); wr(5'h1F, 8'h99);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    m_cs = 0; m_s = 0; m_mi = 0; m_h = 0; m_wd = 0; m_d = 0; m_mo = 0; m_y = 0; m_ph = 0;
    m_stop = 0; m_ceb = 0; m_cb = 0; m_of = 1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (4) @(posedge clk_i);

    // R1 reset state
    expect_rd(5'h01, 8'h80, "R1");
    expect_rd(5'h09, 8'h80, "R1");
    expect_rd(5'h00, 8'h00, "R1");
    expect_rd(5'h1F, 8'h00, "R1");
    expect_rd(5'h02, 8'h00, "R1");

    // R9 clear, then a write of 1 has no effect
    wr(5'h01, 8'h00);
    expect_rd(5'h01, 8'h00, "R9");
    wr(5'h09, 8'h80);
    expect_rd(5'h09, 8'h00, "R9");

    // R2 prescaler
    tk(3); expect_rd(5'h1F, 8'h00, "R2");
    tk(1); expect_rd(5'h1F, 8'h01, "R2");

    // R11 phase cleared by a hundredths write
    tk(2); wr(5'h1F, 8'h10);
    tk(3); expect_rd(5'h1F, 8'h10, "R11");
    tk(1); expect_rd(5'h1F, 8'h11, "R11");

    // R10 write and tick in the same cycle, phase one short of a carry
    tk(3);
    step(1'b1, 5'h06, 8'h05, 1'b1, 1'b1, "R10", 1'b0, 8'h00);
    expect_rd(5'h1F, 8'h11, "R10");
    tk(1); expect_rd(5'h1F, 8'h12, "R10");

    // R6 R5 R4 full rollover with century enabled
    wr(5'h02, 8'h63); wr(5'h01, 8'h59); wr(5'h00, 8'h59); wr(5'h03, 8'h07);
    wr(5'h04, 8'h31); wr(5'h05, 8'h12); wr(5'h06, 8'h99); wr(5'h1F, 8'h99);
    tk(4);
    expect_rd(5'h1F, 8'h00, "R2");
    expect_rd(5'h00, 8'h00, "R3");
    expect_rd(5'h01, 8'h00, "R3");
    expect_rd(5'h02, 8'hC0, "R6");
    expect_rd(5'h03, 8'h01, "R4");
    expect_rd(5'h04, 8'h01, "R5");
    expect_rd(5'h05, 8'h01, "R5");
    expect_rd(5'h06, 8'h00, "R5");

    // R6 century disabled: flag holds
    wr(5'h02, 8'hA3); wr(5'h01, 8'h59); wr(5'h00, 8'h59);
    wr(5'h04, 8'h31); wr(5'h05, 8'h12); wr(5'h06, 8'h99); wr(5'h1F, 8'h99);
    tk(4);
    expect_rd(5'h02, 8'h80, "R6");
    expect_rd(5'h06, 8'h00, "R5");
    expect_rd(5'h03, 8'h02, "R4");

    // R5 month lengths and leap years
    wr(5'h06, 8'h24); wr(5'h05, 8'h02); wr(5'h04, 8'h28); set_eod(); tk(4);
    expect_rd(5'h04, 8'h29, "R5");
    set_eod(); tk(4);
    expect_rd(5'h04, 8'h01, "R5");
    expect_rd(5'h05, 8'h03, "R5");
    wr(5'h06, 8'h23); wr(5'h05, 8'h02); wr(5'h04, 8'h28); set_eod(); tk(4);
    expect_rd(5'h04, 8'h01, "R5");
    wr(5'h06, 8'h12); wr(5'h05, 8'h02); wr(5'h04, 8'h28); set_eod(); tk(4);
    expect_rd(5'h04, 8'h29, "R5");
    wr(5'h05, 8'h04); wr(5'h04, 8'h30); set_eod(); tk(4);
    expect_rd(5'h04, 8'h01, "R5");
    expect_rd(5'h05, 8'h05, "R5");

    // R7 R8 R9 stop bit
    wr(5'h00, 8'h80);
    tk(10);
    expect_rd(5'h1F, 8'h00, "R7");
    expect_rd(5'h01, 8'h80, "R8");
    wr(5'h01, 8'h00);
    expect_rd(5'h01, 8'h80, "R9");
    wr(5'h00, 8'h00);
    wr(5'h09, 8'h00);
    expect_rd(5'h01, 8'h00, "R9");

    // R8 R9 oscillation lost
    step(1'b0, 5'h01, 8'h00, 1'b0, 1'b0, "R8", 1'b0, 8'h00);
    expect_rd(5'h09, 8'h80, "R8");
    step(1'b1, 5'h09, 8'h00, 1'b0, 1'b0, "R9", 1'b0, 8'h00);
    expect_rd(5'h01, 8'h80, "R9");
    wr(5'h01, 8'h00);
    expect_rd(5'h01, 8'h00, "R9");

    // R12 masked and unmapped bits
    wr(5'h03, 8'h87); expect_rd(5'h03, 8'h07, "R12");
    wr(5'h04, 8'hC5); expect_rd(5'h04, 8'h05, "R12");
    wr(5'h05, 8'hE9); expect_rd(5'h05, 8'h09, "R12");
    wr(5'h0A, 8'hFF); expect_rd(5'h0A, 8'h00, "R12");
    wr(5'h09, 8'h7F); expect_rd(5'h09, 8'h00, "R12");

    // long run across minutes, day, month and year with century enabled
    wr(5'h02, 8'h63); wr(5'h01, 8'h59); wr(5'h00, 8'h58); wr(5'h06, 8'h99);
    wr(5'h05, 8'h12); wr(5'h04, 8'h31); wr(5'h03, 8'h03); wr(5'h1F, 8'h00);
    tk(24000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule